// File: doc/BRIEF.md
# Four-Lane Byte FIFO with Word and Byte Ports

This block is the data buffer that sits between a bus-facing register port and a serial shifter. Storage is four independent 16-entry byte lanes. The word port moves a full 32-bit word in one cycle by pushing or popping one byte in every lane. Lane 0 carries the least significant byte. The byte port moves one byte through lane 0 alone. A word path therefore sees 64 bytes of room, and a byte path sees 16.

Read data is show-ahead: the head bytes are on the outputs before the pop. A driver polls a six-bit status word. Five of its bits follow the fill level. The sixth records an access that was refused. Every bit is sticky and is cleared by writing a one to the same position of `clr_i`. A level bit then reads zero for one cycle. It is set again on the following cycle if its condition still holds, so clearing and then reading gives the current level.

A small fill-level state machine tracks the whole store. Its states are FILL_EMPTY, FILL_PART, FILL_HALF and FILL_FULL. The next state is chosen from the lane counts as they will be after the current cycle's accesses, in this priority order:
- FILL_FULL when any lane will hold 16 entries.
- Otherwise FILL_HALF when any lane will hold 8 or more entries.
- Otherwise FILL_EMPTY when every lane will be empty.
- Otherwise FILL_PART.

Any state can move to any other state in one cycle. The full, half and empty conditions are decoded from this state.

Top module: `fifo4`

## Requirements
- R1: A word write stores byte i of the word (bits 8i+7..8i) in lane i. A word read pops one byte from every lane and returns lane i's head in bits 8i+7..8i, so words come back in first-in first-out order.
- R2: A byte write pushes only into lane 0 and a byte read pops only from lane 0. `rd_byte_data_o` shows lane 0's head.
- R3: A word write is accepted only when no lane holds 16 entries, giving 16 words (64 bytes) of capacity. A refused word write changes no stored data.
- R4: A byte write is accepted only when lane 0 holds fewer than 16 entries, giving 16 bytes of capacity.
- R5: A word read is accepted only when every lane holds at least one entry, and a byte read only when lane 0 does. A refused read pops nothing.
- R6: When word and byte enables of the same direction are raised together, the word access proceeds under its own rules and the byte access is refused.
- R7: Status bit 0 (full) is set when any lane holds 16 entries.
- R8: Status bit 1 (half) is set when any lane holds 8 or more entries.
- R9: Status bit 2 (empty) is set when all lanes are empty.
- R10: Status bit 3 (word available) is set when every lane holds at least one entry. Status bit 4 (byte available) is set when lane 0 holds at least one entry.
- R11: Bits 0 to 4 are sticky. A one in `clr_i` zeroes that bit on the next edge. The bit is set again one edge later if its condition holds.
- R12: Status bit 5 (illegal access) is set on the edge after any refused access, whether write or read. It stays set until cleared. A refused access in the same cycle as its clear keeps the bit set.
- R13: Reset empties all lanes and zeroes the status word. The empty bit appears on the first edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_word_i | input | 1 | Push one word across all lanes |
| wr_word_data_i | input | 32 | Word to push, lane 0 in the low byte |
| wr_byte_i | input | 1 | Push one byte into lane 0 |
| wr_byte_data_i | input | 8 | Byte to push |
| rd_word_i | input | 1 | Pop one byte from every lane |
| rd_byte_i | input | 1 | Pop one byte from lane 0 |
| rd_word_data_o | output | 32 | Heads of all lanes, lane 0 in the low byte |
| rd_byte_data_o | output | 8 | Head of lane 0 |
| clr_i | input | 6 | Write-one-to-clear mask for the status bits |
| stat_o | output | 6 | Status: 0 full, 1 half, 2 empty, 3 word available, 4 byte available, 5 illegal access |

## Verification
A lane pointer or count that drifts out of step with its neighbours shows up on the word read port. The returned word mixes bytes from different writes, or a read that should succeed is refused and bit 5 rises. A count error surfaces two edges after the faulty access, once a clear and re-sample has run: the full, half or available bits disagree with the number of words written. A wrong fill state shows up as a wrong bit in that same re-sample window, so every fill threshold is checked just below and just at its boundary.

// File: rtl/fifo4_pkg.sv
package fifo4_pkg;
    typedef enum logic [1:0] {
        FILL_EMPTY,
        FILL_PART,
        FILL_HALF,
        FILL_FULL
    } fill_e;

    localparam int STAT_W    = 6;
    localparam int BIT_FULL  = 0;
    localparam int BIT_HALF  = 1;
    localparam int BIT_EMPTY = 2;
    localparam int BIT_AV32  = 3;
    localparam int BIT_AV8   = 4;
    localparam int BIT_ILL   = 5;
endpackage

// File: rtl/fifo4_lane.sv
module fifo4_lane #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign dout = mem[rp];
endmodule

// File: rtl/fifo4_fill_fsm.sv
module fifo4_fill_fsm
    import fifo4_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  any_full_n,
    input  logic  any_half_n,
    input  logic  all_empty_n,
    output logic  full,
    output logic  half,
    output logic  empty
);
    fill_e state, state_n;

    always_comb begin
        if (any_full_n)       state_n = FILL_FULL;
        else if (any_half_n)  state_n = FILL_HALF;
        else if (all_empty_n) state_n = FILL_EMPTY;
        else                  state_n = FILL_PART;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= FILL_EMPTY;
        else        state <= state_n;
    end

    always_comb begin
        full  = 1'b0;
        half  = 1'b0;
        empty = 1'b0;
        unique case (state)
            FILL_EMPTY: empty = 1'b1;
            FILL_PART:  ;
            FILL_HALF:  half = 1'b1;
            FILL_FULL: begin
                full = 1'b1;
                half = 1'b1;
            end
            default:    ;
        endcase
    end
endmodule

// File: rtl/fifo4.sv
module fifo4
    import fifo4_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int HALF = DEPTH / 2,
    localparam int WW   = LANES * W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_word_i,
    input  logic [WW-1:0]     wr_word_data_i,
    input  logic              wr_byte_i,
    input  logic [W-1:0]      wr_byte_data_i,
    input  logic              rd_word_i,
    input  logic              rd_byte_i,
    output logic [WW-1:0]     rd_word_data_o,
    output logic [W-1:0]      rd_byte_data_o,
    input  logic [STAT_W-1:0] clr_i,
    output logic [STAT_W-1:0] stat_o
);
    logic [LANES-1:0][CW-1:0] cnt;
    logic [LANES-1:0][CW-1:0] cnt_n;
    logic [LANES-1:0][W-1:0]  head;
    logic [LANES-1:0][W-1:0]  din;
    logic [LANES-1:0]         push_v, pop_v;
    logic [LANES*CW-1:0]      cnt_flat;

    logic any_full, all_avail;
    logic wacc_w, wacc_b, racc_w, racc_b, ill_evt;
    logic any_full_n, any_half_n, all_empty_n;
    logic lvl_full, lvl_half, lvl_empty;
    logic [STAT_W-1:0] cond;

    always_comb begin
        any_full  = 1'b0;
        all_avail = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            if (cnt[i] == CW'(DEPTH)) any_full  = 1'b1;
            if (cnt[i] == '0)         all_avail = 1'b0;
        end
    end

    assign wacc_w  = wr_word_i && !any_full;
    assign wacc_b  = wr_byte_i && !wr_word_i && (cnt[0] != CW'(DEPTH));
    assign racc_w  = rd_word_i && all_avail;
    assign racc_b  = rd_byte_i && !rd_word_i && (cnt[0] != '0);
    assign ill_evt = (wr_word_i && !wacc_w) || (wr_byte_i && !wacc_b) ||
                     (rd_word_i && !racc_w) || (rd_byte_i && !racc_b);

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            push_v[i] = wacc_w || ((i == 0) && wacc_b);
            pop_v[i]  = racc_w || ((i == 0) && racc_b);
            din[i]    = wacc_w ? wr_word_data_i[i*W +: W] : wr_byte_data_i;
            cnt_n[i]  = cnt[i] + CW'(push_v[i]) - CW'(pop_v[i]);
        end
    end

    always_comb begin
        any_full_n  = 1'b0;
        any_half_n  = 1'b0;
        all_empty_n = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            if (cnt_n[i] == CW'(DEPTH)) any_full_n  = 1'b1;
            if (cnt_n[i] >= CW'(HALF))  any_half_n  = 1'b1;
            if (cnt_n[i] != '0)         all_empty_n = 1'b0;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fifo4_lane #(.DEPTH(DEPTH), .W(W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push_v[g]),
            .din   (din[g]),
            .pop   (pop_v[g]),
            .dout  (head[g]),
            .count (cnt[g])
        );
        assign cnt_flat[g*CW +: CW] = cnt[g];
    end

    fifo4_fill_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_full_n  (any_full_n),
        .any_half_n  (any_half_n),
        .all_empty_n (all_empty_n),
        .full        (lvl_full),
        .half        (lvl_half),
        .empty       (lvl_empty)
    );

    always_comb begin
        cond            = '0;
        cond[BIT_FULL]  = lvl_full;
        cond[BIT_HALF]  = lvl_half;
        cond[BIT_EMPTY] = lvl_empty;
        cond[BIT_AV32]  = all_avail;
        cond[BIT_AV8]   = (cnt[0] != '0);
        cond[BIT_ILL]   = ill_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_o <= '0;
        end else begin
            stat_o[BIT_AV8:0] <= (stat_o[BIT_AV8:0] | cond[BIT_AV8:0]) & ~clr_i[BIT_AV8:0];
            stat_o[BIT_ILL]   <= (stat_o[BIT_ILL] & ~clr_i[BIT_ILL]) | cond[BIT_ILL];
        end
    end

    assign rd_word_data_o = head;
    assign rd_byte_data_o = head[0];
endmodule

// File: rtl/fifo4_chk.sv
module fifo4_chk #(
    parameter int LANES = 4,
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_word_i,
    input logic                wr_byte_i,
    input logic                rd_word_i,
    input logic                rd_byte_i,
    input logic [5:0]          clr_i,
    input logic [5:0]          stat_o,
    input logic [LANES*CW-1:0] cnt_flat
);
    logic any_full, all_zero;
    logic [CW-1:0] lane0;

    assign lane0 = cnt_flat[CW-1:0];

    always_comb begin
        any_full = 1'b0;
        all_zero = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            if (cnt_flat[i*CW +: CW] == CW'(DEPTH)) any_full = 1'b1;
            if (cnt_flat[i*CW +: CW] != '0)         all_zero = 1'b0;
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane0 <= CW'(DEPTH));

    // R12
    illegal_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_word_i && any_full) |=> stat_o[5]);

    // R5
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_byte_i && !rd_word_i && !wr_byte_i && !wr_word_i && lane0 == '0)
        |=> ($stable(lane0) && stat_o[5]));

    // R11
    clear_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i[0] |=> !stat_o[0]);

    // R11
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i[2] |=> !stat_o[2]);

    // R9
    empty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (all_zero && !clr_i[2] && !wr_word_i && !wr_byte_i) |=> ##1 (stat_o[2] || $past(clr_i[2])));

    // R7
    full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_full && !clr_i[0]) |=> stat_o[0]);
endmodule

bind fifo4 fifo4_chk #(.LANES(LANES), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_word_i (wr_word_i),
    .wr_byte_i (wr_byte_i),
    .rd_word_i (rd_word_i),
    .rd_byte_i (rd_byte_i),
    .clr_i     (clr_i),
    .stat_o    (stat_o),
    .cnt_flat  (cnt_flat)
);

// File: tb/sim_fifo4.sv
module sim_fifo4;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_word_i = 1'b0, wr_byte_i = 1'b0, rd_word_i = 1'b0, rd_byte_i = 1'b0;
    logic [31:0] wr_word_data_i = '0;
    logic [7:0]  wr_byte_data_i = '0;
    logic [31:0] rd_word_data_o;
    logic [7:0]  rd_byte_data_o;
    logic [5:0]  clr_i = '0;
    logic [5:0]  stat_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] mq [4][$];
    logic exp_ill;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo4 u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_word_i(wr_word_i), .wr_word_data_i(wr_word_data_i),
        .wr_byte_i(wr_byte_i), .wr_byte_data_i(wr_byte_data_i),
        .rd_word_i(rd_word_i), .rd_byte_i(rd_byte_i),
        .rd_word_data_o(rd_word_data_o), .rd_byte_data_o(rd_byte_data_o),
        .clr_i(clr_i), .stat_o(stat_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_levels();
        logic [5:0] e = '0;
        e[2] = 1'b1;
        e[3] = 1'b1;
        for (int i = 0; i < 4; i++) begin
            if (mq[i].size() == DEPTH) e[0] = 1'b1;
            if (mq[i].size() >= DEPTH/2) e[1] = 1'b1;
            if (mq[i].size() != 0) e[2] = 1'b0;
            if (mq[i].size() == 0) e[3] = 1'b0;
        end
        e[4] = (mq[0].size() != 0);
        return e;
    endfunction

    // one access cycle, starting and ending at a falling edge
    task automatic op(input logic ww, input logic [31:0] wd, input logic wb, input logic [7:0] bd,
                      input logic rw, input logic rb, input logic [5:0] clr, input string req);
        logic aw, ab, arw, arb, full_any, avail_all;
        full_any = 1'b0;
        avail_all = 1'b1;
        for (int i = 0; i < 4; i++) begin
            if (mq[i].size() == DEPTH) full_any = 1'b1;
            if (mq[i].size() == 0) avail_all = 1'b0;
        end
        aw  = ww && !full_any;
        ab  = wb && !ww && mq[0].size() < DEPTH;
        arw = rw && avail_all;
        arb = rb && !rw && mq[0].size() > 0;
        exp_ill = (ww && !aw) || (wb && !ab) || (rw && !arw) || (rb && !arb);
        wr_word_i = ww; wr_word_data_i = wd; wr_byte_i = wb; wr_byte_data_i = bd;
        rd_word_i = rw; rd_byte_i = rb; clr_i = clr;
        #1;
        if (arw) chk({req, " word read data"}, rd_word_data_o,
                     {mq[3][0], mq[2][0], mq[1][0], mq[0][0]});
        if (arb) chk({req, " byte read data"}, {24'h0, rd_byte_data_o}, {24'h0, mq[0][0]});
        if (arw) for (int i = 0; i < 4; i++) void'(mq[i].pop_front());
        if (arb) void'(mq[0].pop_front());
        if (aw) for (int i = 0; i < 4; i++) mq[i].push_back(wd[i*8 +: 8]);
        if (ab) mq[0].push_back(bd);
        @(negedge clk);
        wr_word_i = 0; wr_byte_i = 0; rd_word_i = 0; rd_byte_i = 0; clr_i = '0;
    endtask

    task automatic wword(input logic [31:0] d); op(1, d, 0, 0, 0, 0, 0, "R1"); endtask
    task automatic wbyte(input logic [7:0] d);  op(0, 0, 1, d, 0, 0, 0, "R2"); endtask
    task automatic rword(input string req);     op(0, 0, 0, 0, 1, 0, 0, req); endtask
    task automatic rbyte(input string req);     op(0, 0, 0, 0, 0, 1, 0, req); endtask

    task automatic check_ill(input string req);
        @(negedge clk);
        chk({req, " illegal bit"}, {31'h0, stat_o[5]}, {31'h0, exp_ill});
    endtask

    // clear everything, see the zero cycle, then the re-sampled level
    task automatic check_levels(input string req);
        clr_i = 6'h3F;
        @(negedge clk);
        clr_i = '0;
        chk({req, " R11 cleared"}, {26'h0, stat_o}, 32'h0);
        @(negedge clk);
        chk({req, " levels"}, {26'h0, stat_o}, {26'h0, 1'b0, exp_levels()});
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R13 status in reset", {26'h0, stat_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 R9 empty after first edge", {26'h0, stat_o}, 32'h4);
    endtask

    task automatic t_word_roundtrip();
        wword(32'h03020100);
        wword(32'hA7B6C5D4);
        wword(32'h1F2E3D4C);
        check_levels("R10 three words");
        rword("R1");
        rword("R1");
        op(1, 32'h55667788, 0, 0, 1, 0, 0, "R1 concurrent");
        rword("R1");
        check_levels("R9 after drain");
    endtask

    task automatic t_byte_lane0();
        wbyte(8'hAA);
        check_levels("R10 byte only");
        wword(32'h44332211);
        check_levels("R10 mixed");
        rbyte("R2");
        rword("R2");
        check_levels("R2 drained");
    endtask

    task automatic t_word_full();
        for (int k = 0; k < 7; k++) wword(32'h10000000 + k * 32'h01010101);
        check_levels("R8 seven words");
        wword(32'hDEADBEEF);
        check_levels("R8 eight words");
        for (int k = 0; k < 8; k++) wword(32'hC0C1C2C3 ^ k);
        check_levels("R7 sixteen words");
        wword(32'hFFFFFFFF);
        check_ill("R3 word over");
        check_levels("R3 unchanged");
        for (int k = 0; k < 16; k++) rword("R3");
        check_levels("R3 drained");
    endtask

    task automatic t_byte_full();
        for (int k = 0; k < 16; k++) wbyte(8'h40 + 8'(k));
        check_levels("R4 sixteen bytes");
        wbyte(8'hEE);
        check_ill("R4 byte over");
        wword(32'h01020304);
        check_ill("R3 word into full lane");
        for (int k = 0; k < 16; k++) rbyte("R4");
        check_levels("R4 drained");
    endtask

    task automatic t_empty_read();
        rbyte("R5");
        check_ill("R5 byte read empty");
        check_levels("R5 still empty");
        wbyte(8'h5A);
        rword("R5");
        check_ill("R5 word read partial");
        rbyte("R5 byte kept");
        check_levels("R5 drained");
    endtask

    task automatic t_collide();
        op(1, 32'h0BADF00D, 1, 8'h77, 0, 0, 0, "R6 write");
        check_ill("R6 write collision");
        check_levels("R6 one word");
        op(0, 0, 0, 0, 1, 1, 0, "R6 read");
        check_ill("R6 read collision");
        check_levels("R6 drained");
    endtask

    task automatic t_sticky();
        wword(32'h12345678);
        rword("R11");
        @(negedge clk);
        chk("R11 stale word-available bit held", {31'h0, stat_o[3]}, 32'h1);
        check_levels("R11 re-sampled");
        op(0, 0, 0, 0, 0, 1, 6'h20, "R12");
        @(negedge clk);
        chk("R12 event beats clear", {31'h0, stat_o[5]}, 32'h1);
        @(negedge clk);
        chk("R12 sticky", {31'h0, stat_o[5]}, 32'h1);
        check_levels("R12 cleared");
    endtask

    initial begin
        t_reset();
        t_word_roundtrip();
        t_byte_lane0();
        t_word_full();
        t_byte_full();
        t_empty_read();
        t_collide();
        t_sticky();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule